// File: doc/BRIEF.md
# Command Transmit Sequencer for a FIFO-Style Security Module Interface

This block sits on the host side of a register-mapped security module that takes commands through a byte-wide data FIFO. It accepts a command as a byte stream with a valid/ready handshake, together with a length and a start pulse. It then drives a simple register bus master to deliver the command. First it polls the module's status word until the module says it can take a command. It then writes the bytes to the data register in bursts whose size comes from a count field in that status word. After each burst it checks that the module still expects more bytes. When every byte is in, it writes the execute value to the status register.

The last byte of a command is never sent as part of a larger burst. It goes on its own once the module again reports room, so the sequencer can confirm that the expect flag drops exactly when the final byte lands. Every wait for a status condition is bounded. The interval between repeated status reads is one microsecond, derived from the clock through a parameterised divider. The outcome is a one-cycle done pulse, or a one-cycle error pulse with a code that stays readable until the next start.

Top module: `cmd_tx_seq`

## Requirements
- R1: After reset the block is idle: busy, done, err, bus_rd, bus_wr and src_ready are all 0, and no bus request is made while busy is 0.
- R2: A start with cmd_len equal to 0 makes no bus access and raises err for one cycle on the next clock, with err_code 1.
- R3: No data-register write happens before a status read has returned bit 6 (ready for command) set; reads with bit 6 clear are repeated.
- R4: The burst count is the 16-bit field in status bits 23:8. When a status read fails the condition being waited for, the next status read is issued exactly CLK_PER_US+1 cycles after the failed one completed.
- R5: Within one burst the block writes min(burst, remaining-1) bytes. Each byte is written alone to DATA_ADDR in wdata bits 7:0 with bits 31:8 zero, in stream order. After each burst the block reads status again.
- R6: After a burst, status is polled until bit 7 (valid) is set; if bit 3 (expect) is then clear while bytes remain, err pulses with err_code 3.
- R7: The final byte is written by itself, only after a status read with a nonzero burst count. Status is then polled until bit 7 is set; if bit 3 is still set, err pulses with err_code 4.
- R8: On success the block writes 32'h20 to STS_ADDR, then pulses done for one cycle in the cycle after that write is accepted.
- R9: Each wait allows at most MAX_POLLS status reads that fail its condition; when that budget is used up, err pulses with err_code 2 and the block returns to idle.
- R10: A bus request (bus_rd or bus_wr, with address and write data) is held unchanged until bus_rdy is 1, and bus_rd and bus_wr are never both 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a command when idle |
| cmd_len | input | LEN_W | Number of command bytes, sampled with start |
| src_data | input | 8 | Command byte from the source |
| src_valid | input | 1 | Source byte is valid |
| src_ready | output | 1 | Sequencer takes the byte this cycle |
| bus_addr | output | ADDR_W | Register address of the current request |
| bus_wdata | output | 32 | Write data of the current request |
| bus_rd | output | 1 | Read request, held until bus_rdy |
| bus_wr | output | 1 | Write request, held until bus_rdy |
| bus_rdata | input | 32 | Read data, valid with bus_rd and bus_rdy |
| bus_rdy | input | 1 | Current request completes this cycle |
| busy | output | 1 | A command is in progress |
| done | output | 1 | One-cycle pulse: command delivered and started |
| err | output | 1 | One-cycle pulse: command aborted |
| err_code | output | 3 | 1 zero length, 2 timeout, 3 overflow, 4 expect stuck; held until next start |

## Verification
The bench builds the sequencer with CLK_PER_US of 4 and MAX_POLLS of 8, so the one-microsecond poll spacing becomes a five-cycle gap that can be measured exactly. At these values the poll budget is exhausted after eight failed reads. This puts both sides of the timeout limit within reach in a few dozen cycles: seven not-ready reads still succeed, eight fail, and likewise for a burst count that stays at zero. An 8-bit length keeps the command streams short while burst counts above, at and below the remaining length are all exercised, with a stalling bus to hold requests.

// File: rtl/cmd_tx_seq_pkg.sv
package cmd_tx_seq_pkg;

    localparam int STS_BIT_CMDRDY = 6;
    localparam int STS_BIT_VALID  = 7;
    localparam int STS_BIT_EXPECT = 3;
    localparam int BURST_LSB      = 8;
    localparam int BURST_W        = 16;
    localparam logic [31:0] GO_WORD = 32'h0000_0020;

    typedef enum logic [2:0] {
        S_IDLE,
        S_READ,
        S_WAIT,
        S_CHECK,
        S_FETCH,
        S_WRITE,
        S_GO
    } state_e;

    typedef enum logic [1:0] {
        W_READY,
        W_BURST,
        W_MID,
        W_END
    } wait_e;

    typedef enum logic [2:0] {
        E_NONE     = 3'd0,
        E_LEN      = 3'd1,
        E_TIMEOUT  = 3'd2,
        E_OVERFLOW = 3'd3,
        E_TAIL     = 3'd4
    } err_e;

endpackage

// File: rtl/cts_us_tick.sv
module cts_us_tick #(
    parameter int DIV = 125
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    output logic tick
);
    localparam int W = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [W-1:0] TOP = W'(DIV - 1);

    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        if (clr || cnt_q == TOP) cnt_d = '0;
        else                     cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign tick = (cnt_q == TOP);
endmodule

// File: rtl/cts_poll_budget.sv
module cts_poll_budget #(
    parameter int LIMIT = 1000000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic inc,
    output logic last
);
    localparam int W = $clog2(LIMIT + 1);
    localparam logic [W-1:0] FINAL = W'(LIMIT - 1);

    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        if (clr)      cnt_d = '0;
        else if (inc) cnt_d = cnt_q + 1'b1;
        else          cnt_d = cnt_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign last = (cnt_q == FINAL);
endmodule

// File: rtl/cmd_tx_seq.sv
module cmd_tx_seq
    import cmd_tx_seq_pkg::*;
#(
    parameter int ADDR_W     = 8,
    parameter int LEN_W      = 16,
    parameter int CLK_PER_US = 125,
    parameter int MAX_POLLS  = 1000000,
    parameter logic [ADDR_W-1:0] STS_ADDR  = 'h18,
    parameter logic [ADDR_W-1:0] DATA_ADDR = 'h24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [LEN_W-1:0]  cmd_len,
    input  logic [7:0]        src_data,
    input  logic              src_valid,
    output logic              src_ready,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [31:0]       bus_wdata,
    output logic              bus_rd,
    output logic              bus_wr,
    input  logic [31:0]       bus_rdata,
    input  logic              bus_rdy,
    output logic              busy,
    output logic              done,
    output logic              err,
    output logic [2:0]        err_code
);
    localparam int CW = (LEN_W > BURST_W) ? LEN_W : BURST_W;

    typedef struct packed {
        state_e             st;
        wait_e              wk;
        logic [LEN_W-1:0]   rem;
        logic [BURST_W-1:0] burst;
        logic [CW-1:0]      cnt;
        logic               last;
        logic [7:0]         data;
        logic               done;
        logic               err;
        err_e               code;
    } regs_t;

    regs_t r_d, r_q;

    logic tick, tick_clr;
    logic poll_clr, poll_inc, poll_last;

    logic [BURST_W-1:0] sts_burst;
    logic               hit;
    logic [CW-1:0]      rem_m1;
    logic [CW-1:0]      burst_ext;

    logic unused_rdata;
    assign unused_rdata = ^{bus_rdata[31:BURST_LSB+BURST_W], bus_rdata[5:4], bus_rdata[2:0]};

    cts_us_tick #(.DIV(CLK_PER_US)) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (tick_clr),
        .tick  (tick)
    );

    cts_poll_budget #(.LIMIT(MAX_POLLS)) u_budget (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (poll_clr),
        .inc   (poll_inc),
        .last  (poll_last)
    );

    assign sts_burst = bus_rdata[BURST_LSB +: BURST_W];
    assign rem_m1    = CW'(r_q.rem) - 1'b1;
    assign burst_ext = CW'(r_q.burst);

    always_comb begin
        unique case (r_q.wk)
            W_READY:      hit = bus_rdata[STS_BIT_CMDRDY];
            W_BURST:      hit = (sts_burst != '0);
            default:      hit = bus_rdata[STS_BIT_VALID];
        endcase
    end

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        r_d.err  = 1'b0;
        tick_clr = 1'b0;
        poll_clr = 1'b0;
        poll_inc = 1'b0;

        unique case (r_q.st)
            S_IDLE: begin
                if (start) begin
                    if (cmd_len == '0) begin
                        r_d.err  = 1'b1;
                        r_d.code = E_LEN;
                    end else begin
                        r_d.code = E_NONE;
                        r_d.rem  = cmd_len;
                        r_d.wk   = W_READY;
                        r_d.st   = S_READ;
                        poll_clr = 1'b1;
                    end
                end
            end
            S_READ: begin
                if (bus_rdy) begin
                    if (hit) begin
                        poll_clr = 1'b1;
                        unique case (r_q.wk)
                            W_MID: begin
                                if (!bus_rdata[STS_BIT_EXPECT]) begin
                                    r_d.err  = 1'b1;
                                    r_d.code = E_OVERFLOW;
                                    r_d.st   = S_IDLE;
                                end else begin
                                    r_d.burst = sts_burst;
                                    r_d.st    = S_CHECK;
                                end
                            end
                            W_END: begin
                                if (bus_rdata[STS_BIT_EXPECT]) begin
                                    r_d.err  = 1'b1;
                                    r_d.code = E_TAIL;
                                    r_d.st   = S_IDLE;
                                end else begin
                                    r_d.st = S_GO;
                                end
                            end
                            default: begin
                                r_d.burst = sts_burst;
                                r_d.st    = S_CHECK;
                            end
                        endcase
                    end else if (poll_last) begin
                        r_d.err  = 1'b1;
                        r_d.code = E_TIMEOUT;
                        r_d.st   = S_IDLE;
                    end else begin
                        poll_inc = 1'b1;
                        tick_clr = 1'b1;
                        r_d.st   = S_WAIT;
                    end
                end
            end
            S_WAIT: begin
                if (tick) r_d.st = S_READ;
            end
            S_CHECK: begin
                if (r_q.burst == '0) begin
                    r_d.wk = W_BURST;
                    r_d.st = S_READ;
                end else if (r_q.rem == LEN_W'(1)) begin
                    r_d.last = 1'b1;
                    r_d.cnt  = CW'(1);
                    r_d.st   = S_FETCH;
                end else begin
                    r_d.last = 1'b0;
                    r_d.cnt  = (burst_ext < rem_m1) ? burst_ext : rem_m1;
                    r_d.st   = S_FETCH;
                end
            end
            S_FETCH: begin
                if (src_valid) begin
                    r_d.data = src_data;
                    r_d.st   = S_WRITE;
                end
            end
            S_WRITE: begin
                if (bus_rdy) begin
                    r_d.rem = r_q.rem - 1'b1;
                    r_d.cnt = r_q.cnt - 1'b1;
                    if (r_q.cnt == CW'(1)) begin
                        r_d.wk   = r_q.last ? W_END : W_MID;
                        r_d.st   = S_READ;
                        poll_clr = 1'b1;
                    end else begin
                        r_d.st = S_FETCH;
                    end
                end
            end
            S_GO: begin
                if (bus_rdy) begin
                    r_d.done = 1'b1;
                    r_d.st   = S_IDLE;
                end
            end
            default: r_d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign src_ready = (r_q.st == S_FETCH);
    assign bus_rd    = (r_q.st == S_READ);
    assign bus_wr    = (r_q.st == S_WRITE) || (r_q.st == S_GO);
    assign bus_addr  = (r_q.st == S_WRITE) ? DATA_ADDR : STS_ADDR;
    assign bus_wdata = (r_q.st == S_WRITE) ? {24'd0, r_q.data} : GO_WORD;
    assign busy      = (r_q.st != S_IDLE);
    assign done      = r_q.done;
    assign err       = r_q.err;
    assign err_code  = r_q.code;
endmodule

// File: rtl/cmd_tx_seq_chk.sv
module cmd_tx_seq_chk #(
    parameter int ADDR_W = 8,
    parameter int LEN_W  = 16,
    parameter logic [ADDR_W-1:0] STS_ADDR  = 'h18,
    parameter logic [ADDR_W-1:0] DATA_ADDR = 'h24
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic [LEN_W-1:0]  cmd_len,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [31:0]       bus_wdata,
    input logic              bus_rd,
    input logic              bus_wr,
    input logic [31:0]       bus_rdata,
    input logic              bus_rdy,
    input logic              busy,
    input logic              done,
    input logic              err,
    input logic [2:0]        err_code
);
    logic ready_seen_q;
    logic unused_chk;
    assign unused_chk = ^{bus_rdata[31:7], bus_rdata[5:0]};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     ready_seen_q <= 1'b0;
        else if (!busy) ready_seen_q <= 1'b0;
        else if (bus_rd && bus_rdy && bus_rdata[6]) ready_seen_q <= 1'b1;
    end

    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!bus_rd && !bus_wr));

    p_pulse_excl_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && err));

    p_zero_len_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && cmd_len == '0) |=> (err && err_code == 3'd1 && !busy));

    p_ready_first_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == DATA_ADDR) |-> ready_seen_q);

    p_byte_lane_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == DATA_ADDR) |-> (bus_wdata[31:8] == 24'd0));

    p_go_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(bus_wr && bus_rdy && bus_addr == STS_ADDR && bus_wdata == 32'h20));

    p_one_strobe_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_rd && bus_wr));

    p_hold_rd_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && !bus_rdy) |=> (bus_rd && $stable(bus_addr)));

    p_hold_wr_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && !bus_rdy) |=> (bus_wr && $stable(bus_addr) && $stable(bus_wdata)));
endmodule

bind cmd_tx_seq cmd_tx_seq_chk #(
    .ADDR_W    (ADDR_W),
    .LEN_W     (LEN_W),
    .STS_ADDR  (STS_ADDR),
    .DATA_ADDR (DATA_ADDR)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .cmd_len   (cmd_len),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rd    (bus_rd),
    .bus_wr    (bus_wr),
    .bus_rdata (bus_rdata),
    .bus_rdy   (bus_rdy),
    .busy      (busy),
    .done      (done),
    .err       (err),
    .err_code  (err_code)
);

// File: tb/sim_cmd_tx_seq.sv
`timescale 1ns/1ps
module sim_cmd_tx_seq;
    localparam int ADDR_W = 8;
    localparam int LEN_W  = 8;
    localparam int DIV    = 4;
    localparam int POLLS  = 8;
    localparam logic [7:0] STS  = 8'h18;
    localparam logic [7:0] DATA = 8'h24;

    typedef struct packed {
        int len; int burst; int nrdy; int zb; int xl; int st; int code; int wr;
    } vec_t;

    localparam int NV = 12;
    localparam vec_t VEC [NV] = '{
        '{1, 4, 0, 0, 1, 0, 0, 1},
        '{5, 2, 0, 0, 5, 0, 0, 5},
        '{9, 16, 0, 0, 9, 1, 0, 9},
        '{4, 1, 3, 0, 4, 0, 0, 4},
        '{3, 3, 7, 0, 3, 0, 0, 3},
        '{3, 3, 8, 0, 3, 0, 2, 0},
        '{2, 4, 0, 3, 2, 0, 0, 2},
        '{2, 4, 0, 9, 2, 0, 2, 0},
        '{2, 4, 0, 8, 2, 0, 0, 2},
        '{6, 2, 0, 0, 3, 0, 3, 4},
        '{4, 8, 0, 0, 6, 0, 4, 4},
        '{0, 4, 0, 0, 0, 0, 1, 0}
    };

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start = 1'b0;
    logic [LEN_W-1:0]  cmd_len = '0;
    logic [7:0]        src_data = 8'hA0;
    logic              src_valid = 1'b1;
    logic              src_ready;
    logic [ADDR_W-1:0] bus_addr;
    logic [31:0]       bus_wdata;
    logic              bus_rd, bus_wr;
    logic [31:0]       bus_rdata = '0;
    logic              bus_rdy = 1'b1;
    logic              busy, done, err;
    logic [2:0]        err_code;

    always #4 clk = ~clk;

    cmd_tx_seq #(
        .ADDR_W(ADDR_W), .LEN_W(LEN_W), .CLK_PER_US(DIV), .MAX_POLLS(POLLS),
        .STS_ADDR(STS), .DATA_ADDR(DATA)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .cmd_len(cmd_len),
        .src_data(src_data), .src_valid(src_valid), .src_ready(src_ready),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_wr(bus_wr),
        .bus_rdata(bus_rdata), .bus_rdy(bus_rdy), .busy(busy), .done(done),
        .err(err), .err_code(err_code)
    );

    int nchk = 0, nfail = 0, cyc = 0;
    int m_nrdy, m_zb, m_burst, m_xl, m_stall;
    int m_rdcnt, m_written, m_go, m_src_idx, m_grp, m_grpmax;
    int m_bad_data, m_bad_order, m_prev_cyc, m_prev_nr, m_gap_n, m_gap_bad;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("  TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    endtask

    // bus slave and byte source model, all driven at the falling edge
    initial begin
        forever begin
            @(negedge clk);
            cyc++;
            if (cyc > 150000) begin
                chk(1'b0, "watchdog", cyc, 150000);
                finish_run();
            end
            bus_rdy  = (m_stall != 0) ? cyc[0] : 1'b1;
            src_data = 8'hA0 + 8'(m_src_idx);
            if (src_ready && src_valid) m_src_idx++;
            if (bus_rd) begin
                logic rb;
                logic [15:0] bf;
                rb = (m_rdcnt >= m_nrdy);
                bf = (rb && m_zb > 0) ? 16'd0 : 16'(m_burst);
                bus_rdata = {8'h00, bf, 1'b1, rb, 2'b00, (m_written < m_xl), 3'b000};
                if (bus_rdy) begin
                    if (m_prev_nr != 0 && m_stall == 0) begin
                        m_gap_n++;
                        if (cyc - m_prev_cyc != DIV + 1) m_gap_bad++;
                    end
                    m_prev_cyc = cyc;
                    m_prev_nr  = rb ? 0 : 1;
                    m_rdcnt++;
                    if (rb && m_zb > 0) m_zb--;
                    if (m_grp > m_grpmax) m_grpmax = m_grp;
                    m_grp = 0;
                end
            end
            if (bus_wr && bus_rdy) begin
                if (bus_addr == DATA) begin
                    if (bus_wdata != {24'd0, 8'hA0 + 8'(m_written)}) m_bad_data++;
                    if (m_rdcnt <= m_nrdy) m_bad_order++;
                    m_written++;
                    m_grp++;
                end else if (bus_addr == STS && bus_wdata == 32'h20) begin
                    m_go++;
                end
            end
        end
    end

    initial begin
        m_nrdy = 0; m_zb = 0; m_burst = 0; m_xl = 0; m_stall = 0;
        m_rdcnt = 0; m_written = 0; m_go = 0; m_src_idx = 0; m_grp = 0; m_grpmax = 0;
        m_bad_data = 0; m_bad_order = 0; m_prev_cyc = 0; m_prev_nr = 0;
        m_gap_n = 0; m_gap_bad = 0;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(!busy && !done && !err, "R1 idle flags", int'(busy), 0);
        chk(!bus_rd && !bus_wr && !src_ready, "R1 no bus strobes", int'(bus_rd | bus_wr), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(!busy && !bus_rd && !bus_wr, "R1 idle after release", int'(busy), 0);

        // stimulus table walk
        for (int i = 0; i < NV; i++) begin
            vec_t v;
            int got, waitc, expmax;
            string tag;
            v = VEC[i];
            m_nrdy = v.nrdy; m_zb = v.zb; m_burst = v.burst; m_xl = v.xl; m_stall = v.st;
            m_rdcnt = 0; m_written = 0; m_go = 0; m_src_idx = 0; m_grp = 0; m_grpmax = 0;
            m_bad_data = 0; m_bad_order = 0; m_prev_nr = 0;
            @(negedge clk);
            start = 1'b1; cmd_len = LEN_W'(v.len);
            @(negedge clk);
            start = 1'b0;
            waitc = 0;
            while (!done && !err && waitc < 3000) begin
                @(negedge clk);
                waitc++;
            end
            got = err ? int'(err_code) : (done ? 0 : -1);
            case (v.code)
                0: tag = "R8 result";
                1: tag = "R2 result";
                2: tag = "R9 result";
                3: tag = "R6 result";
                default: tag = "R7 result";
            endcase
            chk(got == v.code, tag, got, v.code);
            chk(m_written == v.wr, (v.st != 0) ? "R10 bytes under stall" : "R5 byte count",
                m_written, v.wr);
            chk(m_go == ((v.code == 0) ? 1 : 0), "R8 go write", m_go, (v.code == 0) ? 1 : 0);
            chk(m_bad_data == 0, "R5 byte value/order", m_bad_data, 0);
            chk(m_bad_order == 0, "R3 write before ready", m_bad_order, 0);
            if (v.code == 0) begin
                if (m_grp > m_grpmax) m_grpmax = m_grp;
                expmax = (v.len == 1) ? 1 : ((v.burst < v.len - 1) ? v.burst : v.len - 1);
                chk(m_grpmax == expmax, "R7 largest burst, last byte alone", m_grpmax, expmax);
            end
            repeat (2) @(negedge clk);
            chk(!busy, "R1 idle after command", int'(busy), 0);
        end

        // directed: poll spacing after not-ready reads
        chk(m_gap_n > 0, "R4 gaps observed", m_gap_n, 1);
        chk(m_gap_bad == 0, "R4 poll spacing", m_gap_bad, 0);

        // directed: error code held, then cleared by a good command
        chk(err_code == 3'd1, "R2 code held", int'(err_code), 1);
        m_nrdy = 0; m_zb = 0; m_burst = 1; m_xl = 3; m_stall = 0;
        m_rdcnt = 0; m_written = 0; m_go = 0; m_src_idx = 0; m_grp = 0; m_grpmax = 0;
        m_bad_data = 0; m_bad_order = 0;
        @(negedge clk);
        start = 1'b1; cmd_len = LEN_W'(3);
        @(negedge clk);
        start = 1'b0;
        for (int k = 0; k < 3000 && !done && !err; k++) @(negedge clk);
        chk(done && !err, "R8 burst of one", int'(done), 1);
        chk(m_written == 3 && m_grpmax <= 1, "R5 burst of one bytes", m_written, 3);
        finish_run();
    end
endmodule